// File: doc/BRIEF.md
# Key-Protected Control Register Lock

This block is the control-register front end of a non-volatile memory controller. It holds a control register and an interrupt-enable register behind a lock bit. While the lock bit is set, software cannot change either register. A simple register bus drives the block with a write strobe, a read strobe, a byte address and a 32-bit data word.

Software releases the lock by writing two key words in order to a separate key register. A wrong word in either position latches a permanent lock that holds until reset. A key write made while the register is already unlocked latches the same permanent lock. Software can set the lock again by writing 1 to the lock bit. That same write may also change the other control fields.

The block drives the protected control fields and the interrupt enables to the rest of the controller. It also drives an unlocked flag and a permanently-locked flag. The key words are parameters.

Top module: `ctrl_key_lock`

## Requirements
- R1: After reset, the lock (control bit 0) is 1, the permanent-lock flag is 0, and all other control bits and all interrupt-enable bits are 0.
- R2: While the lock is 1, a write to the control register (byte offset 16) changes no control bit.
- R3: While the lock is 1, a write to the interrupt-enable register (byte offset 32) changes no bit.
- R4: While locked and not permanently locked, writing KEY1 and then KEY2 to the key register (byte offset 4) clears the lock on the second write. Writes to other addresses between the two key writes do not disturb the sequence.
- R5: A key write whose value is not the expected word (KEY1 first, KEY2 second) sets the permanent-lock flag and keeps the lock at 1.
- R6: Once the permanent-lock flag is set, it stays set until reset. While it is set, the lock stays 1, and key sequences, control writes and interrupt-enable writes have no effect.
- R7: Any key-register write while unlocked sets the permanent-lock flag and sets the lock to 1.
- R8: While unlocked, a control write stores the data under the writable-field mask (default 0x010300FF) and loads bit 0 into the lock. A write with bit 0 set locks the register and updates the other fields in the same write.
- R9: After software re-locks the register, a later correct key sequence unlocks it again.
- R10: When the read strobe is high, offset 16 returns the control register including the lock, offset 32 returns the interrupt enables, and offset 4 and all other offsets return 0. When the read strobe is low, the read data is 0.
- R11: `unlocked` is the inverse of the lock bit, and `perm_locked` shows the permanent-lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| ctrl_q | output | 32 | Control register contents, lock in bit 0 |
| ie_q | output | 32 | Interrupt-enable register contents |
| unlocked | output | 1 | High while the lock bit is 0 |
| perm_locked | output | 1 | High once a bad or repeated key sequence has occurred |

## Verification
Every register update takes effect on the edge that samples the write. A wrong internal state therefore shows at `ctrl_q`, `ie_q`, `unlocked` or `perm_locked` one cycle after the write that exposes it.

A key sequencer stuck in the wrong step never shows at the ports by itself. It shows only when the next key write unlocks the register too early, or freezes it when it should not. For that reason the bench interleaves partial sequences, unrelated writes, software re-locks and resets.

A permanent-lock flag that clears too early shows at the first later correct sequence, which would then unlock the register.

// File: rtl/ctrl_key_lock.sv
module ctrl_key_lock #(
  parameter int                 ADDR_W    = 10,
  parameter logic [31:0]        KEY1      = 32'h5A3C_96E1,
  parameter logic [31:0]        KEY2      = 32'hA5C3_691E,
  parameter logic [ADDR_W-1:0]  KEY_OFS   = 4,
  parameter logic [ADDR_W-1:0]  CTRL_OFS  = 16,
  parameter logic [ADDR_W-1:0]  IE_OFS    = 32,
  parameter logic [31:0]        CTRL_MASK = 32'h0103_00FF,
  parameter logic [31:0]        IE_MASK   = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       ie_q,
  output logic              unlocked,
  output logic              perm_locked
);
  localparam logic [31:0] FIELD_MASK = CTRL_MASK & ~32'h1;

  logic        lock, frozen, stage;
  logic [31:0] fields, ie_bits;

  wire key_wr  = wr_en && (addr == KEY_OFS);
  wire ctrl_wr = wr_en && (addr == CTRL_OFS);
  wire ie_wr   = wr_en && (addr == IE_OFS);
  wire key_bad = !lock || (stage ? (wdata != KEY2) : (wdata != KEY1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b1;
      frozen  <= 1'b0;
      stage   <= 1'b0;
      fields  <= '0;
      ie_bits <= '0;
    end else begin
      if (key_wr && !frozen) begin
        if (key_bad) begin
          frozen <= 1'b1;
          lock   <= 1'b1;
          stage  <= 1'b0;
        end else if (stage) begin
          lock  <= 1'b0;
          stage <= 1'b0;
        end else begin
          stage <= 1'b1;
        end
      end
      if (ctrl_wr && !lock) begin
        fields <= wdata & FIELD_MASK;
        lock   <= wdata[0];
        stage  <= 1'b0;
      end
      if (ie_wr && !lock) ie_bits <= wdata & IE_MASK;
    end
  end

  assign ctrl_q      = fields | {31'b0, lock};
  assign ie_q        = ie_bits;
  assign unlocked    = ~lock;
  assign perm_locked = frozen;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == CTRL_OFS)    rdata = ctrl_q;
      else if (addr == IE_OFS) rdata = ie_q;
    end
  end

  // R2
  ctrl_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !unlocked) |=> $stable(ctrl_q[31:1]));

  // R3
  ie_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_wr && !unlocked) |=> $stable(ie_q));

  // R4
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && wdata == KEY2));

  // R6
  frozen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_locked |=> (perm_locked && !unlocked));

  // R7
  rekey_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && unlocked) |=> (perm_locked && !unlocked));

  // R11
  frozen_implies_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perm_locked |-> (ctrl_q[0] && !unlocked));
endmodule

// File: tb/test_ctrl_key_lock.sv
module test_ctrl_key_lock;
  localparam int CLK_P = 10;
  localparam logic [31:0] K1 = 32'h5A3C_96E1;
  localparam logic [31:0] K2 = 32'hA5C3_691E;
  localparam logic [31:0] CMASK = 32'h0103_00FF;
  localparam logic [31:0] IMASK = 32'h0000_FFFF;
  localparam logic [9:0] A_KEY = 10'd4, A_CTRL = 10'd16, A_IE = 10'd32;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, ctrl_q, ie_q;
  logic unlocked, perm_locked;

  ctrl_key_lock i_ctrl_key_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q), .ie_q(ie_q),
    .unlocked(unlocked), .perm_locked(perm_locked));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_lock = 1, m_frozen = 0, m_stage = 0;
  logic [31:0] m_ctrl = '0, m_ie = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 1; m_frozen = 0; m_stage = 0; m_ctrl = '0; m_ie = '0;
    end else if (wr_en) begin
      if (addr == A_KEY) begin
        if (!m_frozen) begin
          if (!m_lock || (!m_stage && wdata != K1) || (m_stage && wdata != K2)) begin
            m_frozen = 1; m_lock = 1; m_stage = 0;
          end else if (m_stage) begin
            m_lock = 0; m_stage = 0;
          end else m_stage = 1;
        end
      end else if (addr == A_CTRL && !m_lock) begin
        m_ctrl = wdata & CMASK & ~32'h1; m_lock = wdata[0]; m_stage = 0;
      end else if (addr == A_IE && !m_lock) m_ie = wdata & IMASK;
    end
  end

  function automatic logic [31:0] m_read();
    if (!rd_en) return '0;
    if (addr == A_CTRL) return m_ctrl | {31'b0, m_lock};
    if (addr == A_IE) return m_ie;
    return '0;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    chk(phase, "ctrl_q", ctrl_q, m_ctrl | {31'b0, m_lock});
    chk(phase, "ie_q", ie_q, m_ie);
    chk("R11", "unlocked", {31'b0, unlocked}, {31'b0, !m_lock});
    chk("R11", "perm_locked", {31'b0, perm_locked}, {31'b0, m_frozen});
    chk("R10", "rdata", rdata, m_read());
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #1; wr_en = 1; rd_en = 0; addr = a; wdata = d;
  endtask
  task automatic idle();
    @(posedge clk); #1; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
  endtask
  task automatic rd(logic [9:0] a);
    @(posedge clk); #1; wr_en = 0; rd_en = 1; addr = a;
    @(negedge clk);
  endtask
  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0; wr_en = 0; rd_en = 0;
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    chk("R1", "reset ctrl_q", ctrl_q, 32'h1);
    chk("R1", "reset ie_q", ie_q, 32'h0);
    chk("R1", "reset perm_locked", {31'b0, perm_locked}, 32'h0);

    phase = "R2"; wr(A_CTRL, 32'hFFFF_FFFE); idle(); @(negedge clk);
    chk("R2", "locked ctrl write", ctrl_q, 32'h1);
    phase = "R3"; wr(A_IE, 32'hFFFF_FFFF); idle(); @(negedge clk);
    chk("R3", "locked ie write", ie_q, 32'h0);

    phase = "R4"; wr(A_KEY, K1); wr(A_IE, 32'h5); idle(); @(negedge clk);
    chk("R4", "half sequence still locked", {31'b0, unlocked}, 32'h0);
    wr(A_KEY, K2); idle(); @(negedge clk);
    chk("R4", "unlocked after keys", {31'b0, unlocked}, 32'h1);

    phase = "R8"; wr(A_CTRL, 32'hFFFF_FFAA); wr(A_IE, 32'hABCD_1234); idle(); @(negedge clk);
    chk("R8", "unlocked ctrl write", ctrl_q, 32'h0103_00AA);
    chk("R8", "unlocked ie write", ie_q, 32'h0000_1234);
    rd(A_CTRL); chk("R10", "read ctrl", rdata, 32'h0103_00AA);
    rd(A_IE);   chk("R10", "read ie", rdata, 32'h0000_1234);
    rd(A_KEY);  chk("R10", "read key", rdata, 32'h0);
    rd(10'd8);  chk("R10", "read other", rdata, 32'h0);
    wr(A_CTRL, 32'h0000_0055); idle(); @(negedge clk);
    chk("R8", "relock with fields", ctrl_q, 32'h0000_0055);
    chk("R8", "relocked", {31'b0, unlocked}, 32'h0);

    phase = "R9"; wr(A_KEY, K1); wr(A_KEY, K2); idle(); @(negedge clk);
    chk("R9", "unlock after relock", {31'b0, unlocked}, 32'h1);

    phase = "R7"; wr(A_KEY, K1); idle(); @(negedge clk);
    chk("R7", "rekey freezes", {31'b0, perm_locked}, 32'h1);
    chk("R7", "rekey locks", ctrl_q[0], 32'h1);

    phase = "R6"; wr(A_KEY, K1); wr(A_KEY, K2); wr(A_CTRL, 32'h0); wr(A_IE, 32'h0); idle(); @(negedge clk);
    chk("R6", "frozen ignores keys", {31'b0, unlocked}, 32'h0);
    chk("R6", "frozen ignores ctrl", ctrl_q, 32'h0000_0055);
    chk("R6", "frozen ignores ie", ie_q, 32'h0000_1234);

    phase = "R5"; do_reset();
    chk("R1", "reset clears freeze", {31'b0, perm_locked}, 32'h0);
    wr(A_KEY, K1); wr(A_KEY, K1); idle(); @(negedge clk);
    chk("R5", "bad second word", {31'b0, perm_locked}, 32'h1);
    do_reset();
    wr(A_KEY, K2); idle(); wr(A_KEY, K1); wr(A_KEY, K2); idle(); @(negedge clk);
    chk("R5", "bad first word freezes", {31'b0, perm_locked}, 32'h1);
    chk("R5", "bad first word locked", {31'b0, unlocked}, 32'h0);

    idle(); @(negedge clk);
    finish_run();
  end
endmodule